// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Bank

This block is the output stage of a small programmable logic device. It has ten cells. Each cell takes one sum-of-products term and one enable product term from an external logic array. A three-bit architecture field, set per cell, configures that cell on its own. The field picks registered or combinatorial output, active-high or active-low polarity, and whether the enable comes from the array term or from a shared active-low output-enable input.

Each cell drives a tri-state pin model, given as a driven value plus an enable. The cell's register output always goes back to the array as feedback, so state machines can be built in any mode. The cell also returns an inward pin value, so a disabled pin works as a plain input. All registers share one clock and clear to LOW on reset. A synchronous preload port can force every register to a chosen pattern for test.

Top module: `pld_mc_bank`

## Requirements
- R1: While rst_ni is low, every register and every fb_o bit is 0. With the all-zero configuration, every pin_o bit is then 1.
- R2: On each rising clk_i edge with preload_en_i low, every cell register loads its sum_i bit. In registered mode (cfg bit 1 = 0), the cell's output value is that register.
- R3: In combinatorial mode (cfg bit 1 = 1), the cell's output value is its sum_i bit in the same cycle, with no clock delay.
- R4: Polarity is set by cfg bit 0. With bit 0 = 1, pin_o equals the output value. With bit 0 = 0, pin_o is the inverted output value.
- R5: With cfg bit 2 = 0, pin_oe_o is 1 exactly when oe_ni is 0.
- R6: With cfg bit 2 = 1, pin_oe_o equals the cell's oe_term_i bit.
- R7: fb_o always equals the register contents, in both registered and combinatorial mode.
- R8: When pin_oe_o is 0, in_o carries pin_i. When pin_oe_o is 1, in_o carries pin_o.
- R9: On a rising edge with preload_en_i high, each register loads its preload_i bit instead of sum_i.
- R10: Cell n is configured by cfg_i[3n+2:3n] and no other cell's field affects it. The all-zero field means registered, active-low, with the enable taken from oe_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 30 | Architecture fields, 3 bits per cell (bit0 polarity, bit1 combinatorial, bit2 term enable) |
| sum_i | input | 10 | Sum terms from the array |
| oe_term_i | input | 10 | Enable product terms from the array |
| oe_ni | input | 1 | Shared external output enable, active low |
| preload_en_i | input | 1 | Test preload strobe |
| preload_i | input | 10 | Preload pattern |
| pin_i | input | 10 | Value seen on the pins |
| pin_o | output | 10 | Driven pin value |
| pin_oe_o | output | 10 | Pin driver enable |
| fb_o | output | 10 | Register feedback to the array |
| in_o | output | 10 | Inward pin value to the array |

## Verification
The first pattern applies the all-zero configuration with random sum terms. It separates the clocked, inverted path from the raw sum and shows external-enable control. The second sets all cells to combinatorial, active-high, term-enabled. This tells a same-cycle output apart from a one-cycle-late one. A preload burst with sum terms that differ from the preload pattern shows which source the register took. A long phase with random per-cell fields, enables and pin values then mixes modes across neighbouring cells. This exposes cross-cell field decoding errors and wrong inward pin selection.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  localparam int unsigned ARCH_W = 3;

  typedef struct packed {
    logic oe_term;   // 1: enable from array term, 0: from oe_ni
    logic comb;      // 1: combinatorial, 0: registered
    logic act_high;  // 1: non-inverted pin
  } arch_t;
endpackage

// File: rtl/pld_mc_regs.sv
module pld_mc_regs #(
  parameter int unsigned N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  input  logic         preload_en_i,
  input  logic [N-1:0] preload_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           q_o <= '0;
    else if (preload_en_i) q_o <= preload_i;
    else                   q_o <= d_i;
  end

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preload_en_i && $past(rst_ni)) |=> (q_o == $past(d_i)));

  assert_preload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_en_i |=> (q_o == $past(preload_i)));
endmodule

// File: rtl/pld_mc_cell.sv
module pld_mc_cell
  import pld_mc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  arch_t arch_i,
  input  logic  sum_i,
  input  logic  q_i,
  input  logic  oe_term_i,
  input  logic  oe_ni,
  input  logic  pin_i,
  output logic  pin_o,
  output logic  pin_oe_o,
  output logic  in_o
);
  logic val;

  always_comb begin
    val      = arch_i.comb ? sum_i : q_i;
    pin_o    = arch_i.act_high ? val : ~val;
    pin_oe_o = arch_i.oe_term ? oe_term_i : ~oe_ni;
    in_o     = pin_oe_o ? pin_o : pin_i;
  end

  assert_ext_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arch_i.oe_term |-> (pin_oe_o == !oe_ni));

  assert_term_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arch_i.oe_term |-> (pin_oe_o == oe_term_i));

  assert_comb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arch_i.comb |-> (pin_o == (arch_i.act_high ? sum_i : !sum_i)));

  assert_inward_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> (in_o == pin_i));
endmodule

// File: rtl/pld_mc_bank.sv
module pld_mc_bank
  import pld_mc_pkg::*;
#(
  parameter int unsigned N = 10,
  localparam int unsigned CFG_W = N * ARCH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [N-1:0]     sum_i,
  input  logic [N-1:0]     oe_term_i,
  input  logic             oe_ni,
  input  logic             preload_en_i,
  input  logic [N-1:0]     preload_i,
  input  logic [N-1:0]     pin_i,
  output logic [N-1:0]     pin_o,
  output logic [N-1:0]     pin_oe_o,
  output logic [N-1:0]     fb_o,
  output logic [N-1:0]     in_o
);
  logic [N-1:0] q;

  pld_mc_regs #(.N(N)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .d_i          (sum_i),
    .preload_en_i (preload_en_i),
    .preload_i    (preload_i),
    .q_o          (q)
  );

  assign fb_o = q;

  for (genvar g = 0; g < N; g++) begin : g_cell
    pld_mc_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .arch_i    (arch_t'(cfg_i[g*ARCH_W +: ARCH_W])),
      .sum_i     (sum_i[g]),
      .q_i       (q[g]),
      .oe_term_i (oe_term_i[g]),
      .oe_ni     (oe_ni),
      .pin_i     (pin_i[g]),
      .pin_o     (pin_o[g]),
      .pin_oe_o  (pin_oe_o[g]),
      .in_o      (in_o[g])
    );
  end

  assert_fb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (fb_o == $past(preload_en_i ? preload_i : sum_i)));
endmodule

// File: tb/pld_mc_bank_bench.sv
module pld_mc_bank_bench;
  localparam int N = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [3*N-1:0] cfg_i = '0;
  logic [N-1:0] sum_i = '0, oe_term_i = '0, preload_i = '0, pin_i = '0;
  logic oe_ni = 1'b0, preload_en_i = 1'b0;
  logic [N-1:0] pin_o, pin_oe_o, fb_o, in_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] q_m = '0;

  always #10 clk_i = ~clk_i;

  pld_mc_bank u_pld_mc_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .sum_i(sum_i),
    .oe_term_i(oe_term_i), .oe_ni(oe_ni), .preload_en_i(preload_en_i),
    .preload_i(preload_i), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .fb_o(fb_o), .in_o(in_o)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] r;
    for (int c = 0; c < N; c++) r[c] = cfg_i[3*c+2] ? oe_term_i[c] : ~oe_ni;
    return r;
  endfunction

  function automatic logic [N-1:0] exp_pin();
    logic [N-1:0] r;
    for (int c = 0; c < N; c++) begin
      logic v;
      v = cfg_i[3*c+1] ? sum_i[c] : q_m[c];
      r[c] = cfg_i[3*c] ? v : ~v;
    end
    return r;
  endfunction

  // inputs already driven at negedge; check, then clock and advance model
  task automatic step(input string pin_tag);
    logic [N-1:0] oe, p;
    #5;
    oe = exp_oe();
    p  = exp_pin();
    chk("R2 R7 R9 fb", fb_o, q_m);
    chk("R5 R6 oe", pin_oe_o, oe);
    chk(pin_tag, pin_o & oe, p & oe);
    chk("R8 inward", in_o, (p & oe) | (pin_i & ~oe));
    @(posedge clk_i);
    q_m = preload_en_i ? preload_i : sum_i;
    @(negedge clk_i);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    sum_i = 10'h3A5;
    #25;
    chk("R1 reset fb", fb_o, '0);
    chk("R1 reset pin", pin_o, '1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    q_m = '0;

    // default config: registered, inverted, external enable
    for (int i = 0; i < 20; i++) begin
      sum_i = N'($urandom); oe_term_i = N'($urandom); pin_i = N'($urandom);
      oe_ni = (i % 5 == 4);
      step("R10 R2 R4 default pin");
    end

    // combinatorial, active high, term enable
    for (int c = 0; c < N; c++) cfg_i[3*c +: 3] = 3'b111;
    for (int i = 0; i < 20; i++) begin
      sum_i = N'($urandom); oe_term_i = N'($urandom); pin_i = N'($urandom);
      oe_ni = 1'(($urandom));
      step("R3 R4 comb pin");
    end

    // preload burst with differing sum terms
    cfg_i = '0; oe_ni = 1'b0;
    for (int i = 0; i < 8; i++) begin
      preload_en_i = 1'b1;
      preload_i = N'($urandom); sum_i = ~preload_i;
      step("R9 preload pin");
    end
    preload_en_i = 1'b0;
    sum_i = '0;
    step("R9 after preload pin");

    // mixed per-cell fields
    for (int i = 0; i < 400; i++) begin
      cfg_i = 30'($urandom);
      sum_i = N'($urandom); oe_term_i = N'($urandom); pin_i = N'($urandom);
      oe_ni = 1'($urandom); preload_en_i = ($urandom % 8 == 0);
      preload_i = N'($urandom);
      step("R10 R4 R7 mixed pin");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule